// File: doc/BRIEF.md
# Core Low-Power Wait Controller

This block sequences a processor core into and out of its idle state for the two wait instructions: wait-for-interrupt and wait-for-event. When the core issues a wait request, the controller keeps the core clock running until the pipeline and all earlier memory traffic report that they have drained. It then gates the clock and raises the standby flag that matches the kind of wait. While the core sleeps, snoop, cache/TLB/branch-predictor maintenance and debug-bus requests can briefly turn the clock back on. The standby flag stays high during that time, and the clock is gated again when the servicing logic reports completion.

Wake-up is driven by the active-low IRQ and FIQ lines, which are first passed through a synchronizer. The external event input also wakes the core, but only from wait-for-event. A one-bit event register remembers event edges. A wait-for-event issued while that register is set completes at once, clears the register and does not sleep. The wake path has a fixed cycle bound that includes the synchronizer latency.

Top module: `cw_wait_ctrl`

## Requirements
- R1: After reset, clk_en is 1, idle_wfi and idle_wfe are 0, and the event register is clear, so the first wait-for-event issued enters sleep.
- R2: A wait request accepted in the run state keeps clk_en at 1 and both idle outputs at 0 until drained is sampled at 1. In the next cycle, clk_en drops to 0 and the idle output rises.
- R3: wait_kind 0 selects wait-for-interrupt and raises only idle_wfi. wait_kind 1 selects wait-for-event and raises only idle_wfe. The two idle outputs are never high together.
- R4: While the core sleeps, a request on snoop_req, maint_req or dbg_req sets clk_en to 1 in the next cycle, and the idle output stays high.
- R5: During such a service window, clk_en stays at 1 until svc_done is seen. In the cycle after svc_done, clk_en returns to 0 with the idle output still high, unless a wake source is present.
- R6: Wait-for-event wakes when evt_in goes high, and also when IRQ or FIQ is asserted. Leaving wait-for-event clears the event register.
- R7: Wait-for-interrupt ignores evt_in: idle_wfi stays high while the event input toggles.
- R8: After irq_n or fiq_n is driven low during sleep, the idle output falls within 10 clock cycles, counting the two-flop synchronizer.
- R9: If a wake source and svc_done occur in the same cycle, wake wins. The next cycle has clk_en at 1 and both idle outputs at 0, and the clock is not gated again.
- R10: A rising edge of the synchronized evt_in sets the event register. A wait-for-event request made while the register is set does not enter sleep: both idle outputs stay 0 and clk_en stays 1. The request clears the register, so the next wait-for-event sleeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | Single-cycle wait instruction request |
| wait_kind | input | 1 | 0 = wait-for-interrupt, 1 = wait-for-event |
| drained | input | 1 | Pipeline and earlier memory accesses complete |
| irq_n | input | 1 | Asynchronous active-low interrupt |
| fiq_n | input | 1 | Asynchronous active-low fast interrupt |
| evt_in | input | 1 | Asynchronous external event, active high |
| snoop_req | input | 1 | L1 data cache snoop needs the clock |
| maint_req | input | 1 | Cache/TLB/branch-predictor maintenance needs the clock |
| dbg_req | input | 1 | Debug/trace bus access needs the clock |
| svc_done | input | 1 | Servicing logic finished; clock may be gated again |
| clk_en | output | 1 | Core clock enable |
| idle_wfi | output | 1 | Core idle in wait-for-interrupt |
| idle_wfe | output | 1 | Core idle in wait-for-event |

## Verification
The end of a service window and a synchronized wake request can land in the same cycle. In that case the controller must choose between gating the clock again and leaving standby. The bench provokes this by driving irq_n low exactly two cycles before it pulses svc_done, so the synchronizer output and svc_done are sampled at the same edge. It then judges the following cycles: clk_en must stay 1 and idle_wfe must fall, with no gated cycle in between.

// File: rtl/cw_pkg.sv
package cw_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_SLEEP   = 2'd2,
    ST_SERVICE = 2'd3
  } cw_state_e;

  typedef enum logic {
    KIND_WFI = 1'b0,
    KIND_WFE = 1'b1
  } cw_kind_e;

  // A wake source for the current kind of wait
  function automatic logic wake_hit(cw_kind_e kind, logic irq_s_n,
                                    logic fiq_s_n, logic evt_flag);
    return (!irq_s_n) || (!fiq_s_n) || ((kind == KIND_WFE) && evt_flag);
  endfunction

  // Event register update: a new edge beats a simultaneous clear
  function automatic logic evt_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // Edges from pin change to idle output drop on the interrupt path
  function automatic int unsigned wake_cycles(int unsigned stages);
    return stages + 1;
  endfunction

endpackage

// File: rtl/cw_sync.sv
module cw_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cw_event_reg.sv
module cw_event_reg
  import cw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_s,
  input  logic evt_clr,
  output logic evt_edge,
  output logic evt_flag
);
  logic evt_q;

  assign evt_edge = evt_s & ~evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q    <= 1'b0;
      evt_flag <= 1'b0;
    end else begin
      evt_q    <= evt_s;
      evt_flag <= evt_next(evt_flag, evt_edge, evt_clr);
    end
  end
endmodule

// File: rtl/cw_fsm.sv
module cw_fsm
  import cw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic wait_kind,
  input  logic drained,
  input  logic irq_s_n,
  input  logic fiq_s_n,
  input  logic evt_flag,
  input  logic svc_req,
  input  logic svc_done,
  output logic clk_en,
  output logic idle_wfi,
  output logic idle_wfe,
  output logic evt_clr,
  output logic wake_now,
  output logic in_service
);
  cw_state_e st_q, st_d;
  cw_kind_e  kind_q, kind_d;
  logic      asleep;

  assign asleep   = (st_q == ST_SLEEP) || (st_q == ST_SERVICE);
  assign wake_now = asleep && wake_hit(kind_q, irq_s_n, fiq_s_n, evt_flag);

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    evt_clr = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (wait_req) begin
          if (wait_kind && evt_flag) begin
            evt_clr = 1'b1;
          end else begin
            st_d   = ST_DRAIN;
            kind_d = wait_kind ? KIND_WFE : KIND_WFI;
          end
        end
      end
      ST_DRAIN: begin
        if (drained) st_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wake_now)     st_d = ST_RUN;
        else if (svc_req) st_d = ST_SERVICE;
      end
      ST_SERVICE: begin
        if (wake_now)      st_d = ST_RUN;
        else if (svc_done) st_d = ST_SLEEP;
      end
      default: st_d = ST_RUN;
    endcase
    if (wake_now && (kind_q == KIND_WFE)) evt_clr = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      kind_q <= KIND_WFI;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
    end
  end

  assign clk_en     = (st_q != ST_SLEEP);
  assign in_service = (st_q == ST_SERVICE);
  assign idle_wfi   = asleep && (kind_q == KIND_WFI);
  assign idle_wfe   = asleep && (kind_q == KIND_WFE);
endmodule

// File: rtl/cw_wait_ctrl.sv
module cw_wait_ctrl
  import cw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WAKE_LIMIT  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic wait_kind,
  input  logic drained,
  input  logic irq_n,
  input  logic fiq_n,
  input  logic evt_in,
  input  logic snoop_req,
  input  logic maint_req,
  input  logic dbg_req,
  input  logic svc_done,
  output logic clk_en,
  output logic idle_wfi,
  output logic idle_wfe
);
  localparam int unsigned SYNC_W    = 3;
  localparam int unsigned WAKE_PATH = wake_cycles(SYNC_STAGES);
  localparam logic [SYNC_W-1:0] SYNC_RST = 3'b011;

  logic [SYNC_W-1:0] sync_in, sync_out;
  logic irq_s_n, fiq_s_n, evt_s;
  logic evt_edge, evt_flag, evt_clr;
  logic svc_req, wake_now, in_service;

  assign sync_in = {evt_in, fiq_n, irq_n};

  cw_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .din (sync_in),
    .dout(sync_out)
  );

  assign irq_s_n = sync_out[0];
  assign fiq_s_n = sync_out[1];
  assign evt_s   = sync_out[2];
  assign svc_req = snoop_req | maint_req | dbg_req;

  cw_event_reg u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_s   (evt_s),
    .evt_clr (evt_clr),
    .evt_edge(evt_edge),
    .evt_flag(evt_flag)
  );

  cw_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_req  (wait_req),
    .wait_kind (wait_kind),
    .drained   (drained),
    .irq_s_n   (irq_s_n),
    .fiq_s_n   (fiq_s_n),
    .evt_flag  (evt_flag),
    .svc_req   (svc_req),
    .svc_done  (svc_done),
    .clk_en    (clk_en),
    .idle_wfi  (idle_wfi),
    .idle_wfe  (idle_wfe),
    .evt_clr   (evt_clr),
    .wake_now  (wake_now),
    .in_service(in_service)
  );
endmodule

// File: rtl/cw_wait_ctrl_chk.sv
module cw_wait_ctrl_chk #(
  parameter int unsigned WAKE_LIMIT = 10
) (
  input logic clk,
  input logic rst_n,
  input logic irq_n,
  input logic fiq_n,
  input logic drained,
  input logic snoop_req,
  input logic maint_req,
  input logic dbg_req,
  input logic svc_done,
  input logic clk_en,
  input logic idle_wfi,
  input logic idle_wfe,
  input logic wake_now,
  input logic in_service
);
  logic       idle_any;
  logic [7:0] wake_cnt;

  assign idle_any = idle_wfi | idle_wfe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         wake_cnt <= '0;
    else if (idle_any && (!irq_n || !fiq_n)) begin
      if (wake_cnt != 8'hFF) wake_cnt <= wake_cnt + 8'd1;
    end else                            wake_cnt <= '0;
  end

  a_r2_entry_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_any) |-> $past(drained));

  a_r2_gated_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> idle_any);

  a_r3_one_idle_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_wfi && idle_wfe));

  a_r4_service_opens_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && (snoop_req || maint_req || dbg_req) && !wake_now)
      |=> (clk_en && idle_any));

  a_r5_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && !svc_done && !wake_now) |=> (clk_en && idle_any));

  a_r5_regate_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && svc_done && !wake_now) |=> (!clk_en && idle_any));

  a_r8_wake_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cnt <= 8'(WAKE_LIMIT));

  a_r9_wake_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_any && wake_now) |=> (clk_en && !idle_any));
endmodule

bind cw_wait_ctrl cw_wait_ctrl_chk #(.WAKE_LIMIT(WAKE_LIMIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_n     (irq_n),
  .fiq_n     (fiq_n),
  .drained   (drained),
  .snoop_req (snoop_req),
  .maint_req (maint_req),
  .dbg_req   (dbg_req),
  .svc_done  (svc_done),
  .clk_en    (clk_en),
  .idle_wfi  (idle_wfi),
  .idle_wfe  (idle_wfe),
  .wake_now  (wake_now),
  .in_service(in_service)
);

// File: tb/cw_wait_ctrl_tb.sv
`timescale 1ns/1ps
module cw_wait_ctrl_tb;
  localparam int LIMIT = 10;

  logic clk = 1'b0;
  logic rst_n, wait_req, wait_kind, drained, irq_n, fiq_n, evt_in;
  logic snoop_req, maint_req, dbg_req, svc_done;
  logic clk_en, idle_wfi, idle_wfe;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cw_wait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .wait_kind(wait_kind),
    .drained(drained), .irq_n(irq_n), .fiq_n(fiq_n), .evt_in(evt_in),
    .snoop_req(snoop_req), .maint_req(maint_req), .dbg_req(dbg_req),
    .svc_done(svc_done), .clk_en(clk_en), .idle_wfi(idle_wfi), .idle_wfe(idle_wfe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_le(input string req, input int act, input int lim);
    n_chk++;
    if (act > lim || act == 0) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=1..%0d", req, act, lim);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // Pulse a wait request; with drained already 1 the core sleeps two edges later
  task automatic issue(input logic kind);
    @(negedge clk); wait_req = 1'b1; wait_kind = kind;
    @(negedge clk); wait_req = 1'b0;
    @(negedge clk);
  endtask

  // Count edges from an input change (made at a negedge) until idle drops
  task automatic count_wake(output int cyc);
    cyc = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      cyc++;
      if (!(idle_wfi || idle_wfe)) break;
    end
  endtask

  task automatic t_reset();
    int cyc;
    rst_n = 1'b0; wait_req = 0; wait_kind = 0; drained = 1; irq_n = 1; fiq_n = 1;
    evt_in = 0; snoop_req = 0; maint_req = 0; dbg_req = 0; svc_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 clk_en after reset", clk_en, 1);
    chk("R1 idle_wfi after reset", idle_wfi, 0);
    chk("R1 idle_wfe after reset", idle_wfe, 0);
    issue(1'b1);
    chk("R1 first WFE sleeps (event reg clear)", idle_wfe, 1);
    chk("R3 WFE leaves idle_wfi low", idle_wfi, 0);
    fiq_n = 1'b0;
    count_wake(cyc);
    chk_le("R6 R8 WFE wakes on FIQ within bound", cyc, LIMIT);
    chk("R6 clk_en after FIQ wake", clk_en, 1);
    @(negedge clk); fiq_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_wfi_entry();
    int cyc;
    drained = 1'b0;
    issue(1'b0);
    repeat (3) @(negedge clk);
    chk("R2 clock on while draining", clk_en, 1);
    chk("R2 not idle while draining", idle_wfi, 0);
    drained = 1'b1;
    @(negedge clk);
    chk("R2 idle_wfi after drain", idle_wfi, 1);
    chk("R2 clock gated after drain", clk_en, 0);
    chk("R3 WFI leaves idle_wfe low", idle_wfe, 0);
    evt_in = 1'b1;
    repeat (3) @(negedge clk);
    evt_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 WFI ignores event", idle_wfi, 1);
    chk("R7 clock still gated", clk_en, 0);
    irq_n = 1'b0;
    count_wake(cyc);
    chk_le("R8 WFI wakes on IRQ within bound", cyc, LIMIT);
    @(negedge clk); irq_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // The event from t_wfi_entry left the register set
  task automatic t_wfe_skip();
    int cyc;
    issue(1'b1);
    chk("R10 pending event: no idle", idle_wfe, 0);
    chk("R10 pending event: clock on", clk_en, 1);
    repeat (3) @(negedge clk);
    chk("R10 still running", idle_wfe, 0);
    issue(1'b1);
    chk("R10 register cleared, next WFE sleeps", idle_wfe, 1);
    evt_in = 1'b1;
    count_wake(cyc);
    chk_le("R6 WFE wakes on event", cyc, LIMIT);
    @(negedge clk); evt_in = 1'b0;
    repeat (4) @(negedge clk);
    issue(1'b1);
    chk("R6 event consumed on wake", idle_wfe, 1);
    irq_n = 1'b0;
    count_wake(cyc);
    chk_le("R6 WFE wakes on IRQ", cyc, LIMIT);
    @(negedge clk); irq_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_service();
    int cyc;
    issue(1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      snoop_req = (k == 0); maint_req = (k == 1); dbg_req = (k == 2);
      @(negedge clk);
      snoop_req = 0; maint_req = 0; dbg_req = 0;
      chk("R4 service opens clock", clk_en, 1);
      chk("R4 idle held in service", idle_wfi, 1);
      repeat (3) @(negedge clk);
      chk("R5 clock held until done", clk_en, 1);
      svc_done = 1'b1;
      @(negedge clk); svc_done = 1'b0;
      chk("R5 clock regated after done", clk_en, 0);
      chk("R5 idle kept after done", idle_wfi, 1);
    end
    irq_n = 1'b0;
    count_wake(cyc);
    chk_le("R8 wake after service", cyc, LIMIT);
    @(negedge clk); irq_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_collide();
    issue(1'b1);
    @(negedge clk); dbg_req = 1'b1;
    @(negedge clk); dbg_req = 1'b0;
    chk("R4 debug access opens clock", clk_en, 1);
    irq_n = 1'b0;
    @(negedge clk);
    @(negedge clk); svc_done = 1'b1;
    @(negedge clk); svc_done = 1'b0;
    chk("R9 wake beats done: clock on", clk_en, 1);
    chk("R9 wake beats done: idle low", idle_wfe, 0);
    @(negedge clk);
    chk("R9 no regate after collision", clk_en, 1);
    irq_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_wfi_entry();
    t_wfe_skip();
    t_service();
    t_collide();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule